// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous true dual-port memory with two identical ports, left and right. Each port can read or write any word on any clock cycle. Reads are registered: a read issued in one cycle shows on that port's read data in the next cycle. Depth and word width are parameters. A 16K x 16 build uses `ADDR_W = 14`. The default build is smaller so that elaboration stays light.

When both ports are enabled on the same address, an arbiter decides which port owns that word. The port whose access was already in progress wins. The other port sees its busy output go high, and a write it attempts is held in a one-entry buffer. That write lands on the first cycle the port is no longer busy. A strap input selects master or slave mode. In master mode the internal arbiter drives the busy outputs. In slave mode the busy outputs stay low, and each port's busy input alone gates that port's writes.

The two highest words are mailboxes, each tied to an active-low interrupt:
- The top word belongs to the left port.
- The word below the top belongs to the right port.

A committed write by the opposite port into a port's mailbox raises that port's interrupt. The port clears its own interrupt by reading its mailbox with output enable high.

Top module: `dpram_arb`

## Requirements
- R1: A write committed at a port updates the word at its address. A read issued with enable high, write select low and output enable high presents that word on the same port's read data one cycle later. With output enable low, no read occurs and read data holds its value.
- R2: In master mode, a collision is both enables high with equal addresses. At the start of a collision, a port that held the same enabled address in the previous cycle wins against a port that did not. The loser's busy output goes high in the same cycle. Ownership stays unchanged while the collision persists.
- R3: If neither colliding port (or both) held the address in the previous cycle, the left port wins. Only the right busy output goes high, and exactly one busy output is high during any master-mode collision.
- R4: A busy output drops in the same cycle that the addresses stop matching or either enable goes low.
- R5: A write attempted by a busy port does not change the memory while that port stays busy.
- R6: A blocked write is kept and commits on the first cycle its port is not busy. If the port issues a new write in that cycle, the new write is done and the kept write is dropped.
- R7: In slave mode, both busy outputs stay low and the internal arbiter is ignored. A port whose busy input is high has its write blocked and kept as in R6.
- R8: A committed right-port write to the top address drives the left interrupt low from the next cycle. A committed left-port write to the top address minus one does the same for the right interrupt.
- R9: A port's interrupt returns high the cycle after that port reads its own mailbox with output enable high. A read with output enable low leaves it unchanged. A set and a clear in the same cycle leave the interrupt asserted.
- R10: While reset is active, both interrupts are high, both busy outputs are low, both read data outputs are zero, and arbiter ownership is cleared. Memory contents are not reset.
- R11: When one port writes a word in the same cycle the other port reads it, the read returns the previous contents. A read in the next cycle returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master mode (internal arbiter), 0 = slave mode |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left write select (1 = write) |
| l_oe_i | input | 1 | Left output enable for reads |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy input, used in slave mode |
| l_rdata_o | output | DATA_W | Left read data, registered |
| l_busy_o | output | 1 | Left busy output, master mode |
| l_irq_no | output | 1 | Left mailbox interrupt, active low |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right write select (1 = write) |
| r_oe_i | input | 1 | Right output enable for reads |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy input, used in slave mode |
| r_rdata_o | output | DATA_W | Right read data, registered |
| r_busy_o | output | 1 | Right busy output, master mode |
| r_irq_no | output | 1 | Right mailbox interrupt, active low |

## Verification
The bench builds collisions in which one port has held the address for a cycle before the other arrives. A design that ignored arrival order would block the wrong side. It also builds collisions in which both ports arrive together, where a design without a fixed tie rule would raise both busy outputs or neither. Writes blocked in master and slave mode are read back while the port is still busy and again after release, which exposes both a leaking write and a lost write. The remaining cases are:
- A new write issued on the release cycle, to catch a design that commits a stale held value.
- A mailbox write and a mailbox clear in the same cycle, to catch a design that loses the new message.
- A read without output enable, to catch a design that clears the interrupt on it.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NP = 2;
  localparam int PL = 0;
  localparam int PR = 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } own_e;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NP-1:0]     en_i,
  input  logic [ADDR_W-1:0] addr_i [NP],
  output logic [NP-1:0]     busy_o
);
  logic [NP-1:0]     prev_en_q;
  logic [ADDR_W-1:0] prev_addr_q [NP];
  logic [NP-1:0]     held;
  logic              coll;
  own_e              own_q, own_d;

  // a port "held" the address when it was already enabled there last cycle
  for (genvar p = 0; p < NP; p++) begin : g_hist
    assign held[p] = prev_en_q[p] & en_i[p] & (addr_i[p] == prev_addr_q[p]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_en_q[p]   <= 1'b0;
        prev_addr_q[p] <= '0;
      end else begin
        prev_en_q[p]   <= en_i[p];
        prev_addr_q[p] <= addr_i[p];
      end
    end
  end

  assign coll = en_i[PL] & en_i[PR] & (addr_i[PL] == addr_i[PR]);

  always_comb begin
    own_d = OWN_NONE;
    if (coll) begin
      if (own_q != OWN_NONE)           own_d = own_q;
      else if (held[PR] && !held[PL])  own_d = OWN_R;
      else                             own_d = OWN_L;  // earlier left, or tie
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= OWN_NONE;
    else         own_q <= own_d;
  end

  assign busy_o[PL] = coll & (own_d == OWN_R);
  assign busy_o[PR] = coll & (own_d == OWN_L);
endmodule

// File: rtl/dpram_wr_hold.sv
module dpram_wr_hold #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              req, direct, blocked;

  assign req     = en_i & we_i;
  assign direct  = req & ~busy_i;
  assign blocked = req & busy_i;

  // a fresh write supersedes a held one
  assign wr_en_o   = direct | (pend_q & ~busy_i);
  assign wr_addr_o = direct ? addr_i  : pend_addr_q;
  assign wr_data_o = direct ? wdata_i : pend_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (blocked) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
      pend_data_q <= wdata_i;
    end else if (!busy_i) begin
      pend_q      <= 1'b0;
    end
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;
endmodule

// File: rtl/dpram_array.sv
module dpram_array
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NP-1:0]     wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i [NP],
  input  logic [DATA_W-1:0] wr_data_i [NP],
  input  logic [NP-1:0]     rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i [NP],
  output logic [DATA_W-1:0] rd_data_o [NP]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first, left last: left wins a same-word write
  always_ff @(posedge clk_i) begin
    for (int p = NP - 1; p >= 0; p--) begin
      if (wr_en_i[p]) mem[wr_addr_i[p]] <= wr_data_i[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rd_data_o[p] <= '0;
      else if (rd_en_i[p]) rd_data_o[p] <= mem[rd_addr_i[p]];
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_busy_o,
  output logic              l_irq_no,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_busy_o,
  output logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] MB_L = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MB_R = MB_L - 1'b1;

  logic [NP-1:0]     en, we, oe, busy_in, arb_busy, eff_busy;
  logic [NP-1:0]     wr_en, rd_en, irq_n;
  logic [ADDR_W-1:0] addr [NP];
  logic [ADDR_W-1:0] wr_addr [NP];
  logic [DATA_W-1:0] wdata [NP];
  logic [DATA_W-1:0] wr_data [NP];
  logic [DATA_W-1:0] rdata [NP];

  assign en      = {r_en_i, l_en_i};
  assign we      = {r_we_i, l_we_i};
  assign oe      = {r_oe_i, l_oe_i};
  assign busy_in = {r_busy_i, l_busy_i};
  assign addr[PL]  = l_addr_i;
  assign addr[PR]  = r_addr_i;
  assign wdata[PL] = l_wdata_i;
  assign wdata[PR] = r_wdata_i;

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .addr_i (addr),
    .busy_o (arb_busy)
  );

  assign eff_busy = master_i ? arb_busy : busy_in;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN_MB = (p == PL) ? MB_L : MB_R;
    localparam int                OTH    = NP - 1 - p;

    logic set_irq, clr_irq;

    dpram_wr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[p]),
      .we_i      (we[p]),
      .busy_i    (eff_busy[p]),
      .addr_i    (addr[p]),
      .wdata_i   (wdata[p]),
      .wr_en_o   (wr_en[p]),
      .wr_addr_o (wr_addr[p]),
      .wr_data_o (wr_data[p])
    );

    assign rd_en[p] = en[p] & ~we[p] & oe[p];
    assign set_irq  = wr_en[OTH] & (wr_addr[OTH] == OWN_MB);
    assign clr_irq  = rd_en[p] & (addr[p] == OWN_MB);

    dpram_mailbox u_mbox (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_irq),
      .clr_i  (clr_irq),
      .irq_no (irq_n[p])
    );
  end

  dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (addr),
    .rd_data_o (rdata)
  );

  assign l_rdata_o = rdata[PL];
  assign r_rdata_o = rdata[PR];
  assign l_busy_o  = master_i & arb_busy[PL];
  assign r_busy_o  = master_i & arb_busy[PR];
  assign l_irq_no  = irq_n[PL];
  assign r_irq_no  = irq_n[PR];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_en_i,
  input logic              l_we_i,
  input logic              l_oe_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_busy_i,
  input logic              l_busy_o,
  input logic              l_irq_no,
  input logic              r_en_i,
  input logic              r_we_i,
  input logic              r_oe_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_busy_i,
  input logic              r_busy_o,
  input logic              r_irq_no,
  input logic [DATA_W-1:0] l_rdata_o
);
  localparam logic [ADDR_W-1:0] MB_L = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MB_R = MB_L - 1'b1;

  logic coll, r_wr_mb_l, l_wr_mb_r;
  assign coll      = l_en_i & r_en_i & (l_addr_i == r_addr_i);
  assign r_wr_mb_l = r_en_i & r_we_i & (r_addr_i == MB_L) & ~(master_i ? r_busy_o : r_busy_i);
  assign l_wr_mb_r = l_en_i & l_we_i & (l_addr_i == MB_R) & ~(master_i ? l_busy_o : l_busy_i);

  AST_ONE_SIDE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && coll |-> (l_busy_o ^ r_busy_o)); // R3
  AST_BUSY_NEEDS_COLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_o || r_busy_o) |-> coll); // R4
  AST_SLAVE_BUSY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!l_busy_o && !r_busy_o)); // R7
  AST_L_OWNER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && l_busy_o |=> !(master_i && coll) || l_busy_o); // R2
  AST_R_OWNER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && r_busy_o |=> !(master_i && coll) || r_busy_o); // R2
  AST_L_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_wr_mb_l |=> !l_irq_no); // R8
  AST_R_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_mb_r |=> !r_irq_no); // R8
  AST_L_IRQ_CLR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(l_irq_no) |-> $past(l_en_i && !l_we_i && l_oe_i && l_addr_i == MB_L)); // R9
  AST_R_IRQ_CLR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_irq_no) |-> $past(r_en_i && !r_we_i && r_oe_i && r_addr_i == MB_R)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_en_i && !l_we_i && l_oe_i) |=> $stable(l_rdata_o)); // R1
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i),
  .l_en_i(l_en_i), .l_we_i(l_we_i), .l_oe_i(l_oe_i), .l_addr_i(l_addr_i),
  .l_busy_i(l_busy_i), .l_busy_o(l_busy_o), .l_irq_no(l_irq_no),
  .r_en_i(r_en_i), .r_we_i(r_we_i), .r_oe_i(r_oe_i), .r_addr_i(r_addr_i),
  .r_busy_i(r_busy_i), .r_busy_o(r_busy_o), .r_irq_no(r_irq_no),
  .l_rdata_o(l_rdata_o)
);

// File: tb/dpram_arb_tb.sv
`timescale 1ns/1ps
module dpram_arb_tb;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic master_i = 1'b1;
  logic l_en_i, l_we_i, l_oe_i, l_busy_i, r_en_i, r_we_i, r_oe_i, r_busy_i;
  logic [AW-1:0] l_addr_i, r_addr_i;
  logic [DW-1:0] l_wdata_i, r_wdata_i, l_rdata_o, r_rdata_o;
  logic l_busy_o, r_busy_o, l_irq_no, r_irq_no;

  always #2.5 clk_i = ~clk_i;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc++;

  typedef struct {
    int          at;
    bit          port;
    logic [DW-1:0] exp;
    string       tag;
  } rd_exp_t;
  rd_exp_t sbq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare queued read results when due
  always @(negedge clk_i) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      rd_exp_t e;
      logic [DW-1:0] got;
      e = sbq.pop_front();
      got = e.port ? r_rdata_o : l_rdata_o;
      n_run++;
      if (e.at != cyc || got !== e.exp) begin
        n_fail++;
        $display("FAIL %s: read port %0d got %0h expected %0h", e.tag, e.port, got, e.exp);
      end
    end
  end

  task automatic exp_rd(bit port, logic [DW-1:0] v, string tag);
    rd_exp_t e;
    e.at = cyc + 1; e.port = port; e.exp = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drv_l(logic en, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
    l_en_i = en; l_we_i = we; l_oe_i = oe; l_addr_i = a; l_wdata_i = d;
  endtask

  task automatic drv_r(logic en, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
    r_en_i = en; r_we_i = we; r_oe_i = oe; r_addr_i = a; r_wdata_i = d;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    drv_l(0, 0, 0, '0, '0);
    drv_r(0, 0, 0, '0, '0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    l_busy_i = 0; r_busy_i = 0;
    drv_l(0, 0, 0, '0, '0);
    drv_r(0, 0, 0, '0, '0);
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 l_irq", l_irq_no, 1);
    chk("R10 r_irq", r_irq_no, 1);
    chk("R10 busy", {l_busy_o, r_busy_o}, 0);
    chk("R10 rdata", {l_rdata_o, r_rdata_o}, 0);
    rst_ni = 1'b1;
    step();

    // R1 basic write then read
    drv_l(1, 1, 0, 5, 16'h1111); step();
    drv_l(1, 0, 1, 5, 0); exp_rd(0, 16'h1111, "R1 readback"); step();
    drv_l(1, 0, 0, 6, 0); step();
    chk("R1 no read without oe", l_rdata_o, 16'h1111);
    // preloads
    drv_l(1, 1, 0, 10, 16'h0100); step();
    drv_l(1, 1, 0, 30, 16'h0030); step();
    drv_l(1, 1, 0, 40, 16'h0040); step();
    drv_l(0, 0, 0, 0, 0);
    drv_r(1, 1, 0, 6, 16'h0AAA); step();
    idle();

    // R3/R11: simultaneous arrival, left wins; right reads old data
    drv_l(1, 1, 0, 6, 16'h2222);
    drv_r(1, 0, 1, 6, 0);
    #1;
    chk("R3 tie right busy", r_busy_o, 1);
    chk("R3 tie left free", l_busy_o, 0);
    exp_rd(1, 16'h0AAA, "R11 same-cycle old data");
    @(negedge clk_i);
    idle();
    drv_r(1, 0, 1, 6, 0); exp_rd(1, 16'h2222, "R11 next-cycle new data"); step();
    idle();

    // R2/R5/R6: right held address first, left write blocked then released
    drv_r(1, 0, 1, 10, 0); exp_rd(1, 16'h0100, "R1 right read"); step();
    drv_l(1, 1, 0, 10, 16'h3333);
    #1;
    chk("R2 late left busy", l_busy_o, 1);
    chk("R2 early right free", r_busy_o, 0);
    exp_rd(1, 16'h0100, "R5 blocked write invisible");
    @(negedge clk_i);
    #1;
    chk("R2 ownership kept", l_busy_o, 1);
    exp_rd(1, 16'h0100, "R5 still blocked");
    @(negedge clk_i);
    drv_l(0, 0, 0, 0, 0);
    #1;
    chk("R4 enable drop clears busy", l_busy_o, 0);
    exp_rd(1, 16'h0100, "R11 release-cycle old data");
    @(negedge clk_i);
    exp_rd(1, 16'h3333, "R6 held write completed"); step();
    idle();

    // R4 address mismatch clears busy
    drv_r(1, 0, 1, 20, 0); step();
    drv_l(1, 0, 1, 20, 0);
    #1 chk("R4 collision busy", l_busy_o, 1);
    @(negedge clk_i);
    drv_l(1, 0, 1, 21, 0);
    #1 chk("R4 mismatch clears busy", l_busy_o, 0);
    @(negedge clk_i);
    idle();

    // R6 new write supersedes held write
    drv_r(1, 0, 1, 30, 0); step();
    drv_l(1, 1, 0, 30, 16'h4444);
    #1 chk("R6 blocked", l_busy_o, 1);
    @(negedge clk_i);
    drv_r(0, 0, 0, 0, 0);
    drv_l(1, 1, 0, 31, 16'h5555); step();
    drv_l(1, 0, 1, 30, 0); exp_rd(0, 16'h0030, "R6 held write dropped"); step();
    drv_l(1, 0, 1, 31, 0); exp_rd(0, 16'h5555, "R6 new write done"); step();
    idle();

    // R7 slave mode
    master_i = 1'b0;
    l_busy_i = 1'b1;
    drv_l(1, 1, 0, 40, 16'h6666);
    drv_r(1, 0, 1, 40, 0);
    #1 chk("R7 slave busy outputs low", {l_busy_o, r_busy_o}, 0);
    exp_rd(1, 16'h0040, "R7 busy input blocks");
    @(negedge clk_i);
    drv_l(0, 0, 0, 0, 0);
    drv_r(1, 0, 1, 40, 0); exp_rd(1, 16'h0040, "R7 still blocked"); step();
    l_busy_i = 1'b0;
    idle();
    drv_r(1, 0, 1, 40, 0); exp_rd(1, 16'h6666, "R7 released write"); step();
    idle();
    master_i = 1'b1;
    idle();

    // R8 mailbox set
    drv_r(1, 1, 0, TOP, 16'hBEEF); step();
    chk("R8 left irq set", l_irq_no, 0);
    chk("R8 right irq idle", r_irq_no, 1);
    drv_r(0, 0, 0, 0, 0);
    drv_l(1, 1, 0, TOP - 1, 16'hCAFE); step();
    chk("R8 right irq set", r_irq_no, 0);
    idle();

    // R9 mailbox clear
    drv_l(1, 0, 0, TOP, 0); step();
    chk("R9 no clear without oe", l_irq_no, 0);
    drv_l(1, 0, 1, TOP, 0); exp_rd(0, 16'hBEEF, "R9 mailbox data"); step();
    chk("R9 left irq cleared", l_irq_no, 1);
    idle();
    drv_l(1, 1, 0, TOP - 1, 16'h1234);
    drv_r(1, 0, 1, TOP - 1, 0);
    exp_rd(1, 16'hCAFE, "R11 mailbox old data");
    step();
    chk("R9 set beats clear", r_irq_no, 0);
    idle();
    drv_r(1, 0, 1, TOP - 1, 0); exp_rd(1, 16'h1234, "R9 new message"); step();
    chk("R9 right irq cleared", r_irq_no, 1);
    idle();
    idle();

    chk("scoreboard drained", sbq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule